// File: doc/BRIEF.md
# Snooping Coherence Controller for One Shared Line

This block keeps one memory line coherent across `N_CACHE` caches on a snooping bus. Each cache holds a 4-bit state for the line and has a read-request input and a write-request input. When the bus is idle, a fixed-priority arbiter grants one cache per cycle. The granted request then starts a transaction, and every other cache snoops it in the same clock edge.

A read miss or a write miss moves the caches into transient states that record who supplies the line. While any transient state is present, the busy flag is high. The next clock edge is the completion step, and it resolves every transient state at once. Write hits on exclusive copies never leave the requesting cache. A write hit on a shared copy invalidates the other sharers in a single step.

The block exports all cache states, the busy flag, and a sticky flag that records any breach of the coherence invariants.

Top module: `coh_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every cache state is invalid, busy is 0 and violation is 0. The state codes are: invalid=0, shared-clean=1, exclusive-clean=2, exclusive-dirty=3, read-pending=4, write-pending=5, read-pending-from-dirty-owner=6, write-pending-from-dirty-owner=7, sharer-pending=8. Cache i reports its state on `line_state[4*i+3:4*i]`.
- R2: When busy is 0, the lowest-index cache with any request is granted. Within that cache, a write request wins over a read request. Requests from every other cache in that cycle are dropped. All requests made while busy is 1 are dropped and are never replayed.
- R3: A granted read from an invalid cache causes these changes at the next edge:
  - the requester moves to read-pending (4);
  - an exclusive-dirty holder moves to 6;
  - shared-clean and exclusive-clean holders move to 8;
  - busy becomes 1.
- R4: At completion, if any cache is in state 6 or 8, every cache in states 4, 6 and 8 becomes shared-clean.
- R5: At completion, if no cache is in state 6 or 8, a lone read-pending cache becomes exclusive-clean. Two or more read-pending caches would all become shared-clean.
- R6: A granted write from an invalid cache causes these changes at the next edge:
  - the requester moves to write-pending (5);
  - an exclusive-dirty holder moves to 7;
  - every other cache becomes invalid;
  - busy becomes 1.
- R7: At completion, state 5 becomes exclusive-dirty, state 7 becomes invalid, and busy returns to 0 one cycle after it rose.
- R8: The following requests change no state and leave busy at 0:
  - a granted write to an exclusive-dirty copy;
  - a granted read to any valid copy.
  A granted write to an exclusive-clean copy changes only that cache, to exclusive-dirty.
- R9: A granted write to a shared-clean copy makes the writer exclusive-dirty and every other shared-clean copy invalid, in one edge, with busy staying 0.
- R10: The violation flag is sticky until reset. It is set when any of the following holds:
  - a shared-clean copy coexists with an exclusive copy;
  - two exclusive copies exist;
  - a read-pending coexists with a write-pending;
  - two write-pendings exist.
  Under any request sequence it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | N_CACHE | Read request, one bit per cache |
| wr_req | input | N_CACHE | Write request, one bit per cache |
| line_state | output | 4*N_CACHE | Packed state codes, cache i at bits 4*i+3:4*i |
| busy | output | 1 | A transaction is awaiting completion |
| violation | output | 1 | Sticky coherence-invariant breach |

## Verification
The hardest case to reach is a read miss that finds a dirty owner, or one that finds several clean sharers. Each needs a specific history: a silent write on an exclusive copy, or a chain of read misses from different caches. Only then does the next read produce states 6 or 8. A directed sequence builds these histories one step at a time, including simultaneous requests and requests dropped during busy. A long run of random sparse request patterns then walks the four-cache configuration through its reachable states, and a cycle-level model of the protocol in the bench checks every state code each cycle.

// File: rtl/coh_pkg.sv
// Shared types for the single-line coherence controller.
// Assumes state codes are fixed; a value of 4 or above denotes a transient state.
package coh_pkg;
    localparam int STW    = 4;
    localparam int NUM_ST = 9;

    typedef enum logic [STW-1:0] {
        ST_INV = 4'd0,
        ST_SC  = 4'd1,
        ST_EC  = 4'd2,
        ST_ED  = 4'd3,
        ST_RP  = 4'd4,
        ST_WP  = 4'd5,
        ST_RPO = 4'd6,
        ST_WPO = 4'd7,
        ST_SP  = 4'd8
    } line_st_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RDMISS,
        OP_WRMISS,
        OP_UPGRADE,
        OP_SILENT
    } bus_op_t;
endpackage

// File: rtl/coh_arbiter.sv
// Fixed-priority arbiter: grants the lowest-index requester.
// Assumes the caller masks the grant when the bus is busy.
module coh_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_vld
);
    // pick lowest set request bit
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_vld = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt     = '0;
                gnt[i]  = 1'b1;
                gnt_idx = IW'(i);
                gnt_vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_census.sv
// Counts how many caches sit in each state code.
// Assumes every state input holds a legal code.
module coh_census
    import coh_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  line_st_t st  [N],
    output logic [CW-1:0] cnt [NUM_ST]
);
    // tally state occupancy
    always_comb begin
        for (int k = 0; k < NUM_ST; k++) begin
            cnt[k] = '0;
            for (int i = 0; i < N; i++) begin
                if (st[i] == line_st_t'(k)) cnt[k] = cnt[k] + CW'(1);
            end
        end
    end

    // R6
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[int'(ST_WP)] <= CW'(1));
endmodule

// File: rtl/coh_guard.sv
// Sticky detector for breaches of the coherence invariants.
// Assumes counts come from coh_census for the same cycle.
module coh_guard
    import coh_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt [NUM_ST],
    output logic          violation
);
    logic [CW:0] n_excl;
    logic        breach;

    // evaluate the four invariants
    always_comb begin
        n_excl = {1'b0, cnt[int'(ST_EC)]} + {1'b0, cnt[int'(ST_ED)]};
        breach = ((cnt[int'(ST_SC)] != '0) && (n_excl != '0))
              || (n_excl >= (CW+1)'(2))
              || ((cnt[int'(ST_RP)] != '0) && (cnt[int'(ST_WP)] != '0))
              || (cnt[int'(ST_WP)] >= CW'(2));
    end

    // hold the flag until reset
    always_ff @(posedge clk) begin
        if (!rst_n) violation <= 1'b0;
        else        violation <= violation | breach;
    end

    // R10
    no_breach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !violation);
endmodule

// File: rtl/coh_slot.sv
// Per-cache state register with snoop, request and completion logic.
// Assumes op is OP_NONE whenever completing is high.
module coh_slot
    import coh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     granted,
    input  bus_op_t  op,
    input  logic     completing,
    input  logic     any_rpo,
    input  logic     any_sp,
    input  logic     multi_rp,
    output line_st_t st
);
    line_st_t nxt;

    // next-state selection
    always_comb begin
        nxt = st;
        if (completing) begin
            unique case (st)
                ST_RP:         nxt = (any_rpo || any_sp || multi_rp) ? ST_SC : ST_EC;
                ST_RPO, ST_SP: nxt = ST_SC;
                ST_WP:         nxt = ST_ED;
                ST_WPO:        nxt = ST_INV;
                default:       nxt = st;
            endcase
        end else if (granted) begin
            unique case (op)
                OP_RDMISS:             nxt = ST_RP;
                OP_WRMISS:             nxt = ST_WP;
                OP_UPGRADE, OP_SILENT: nxt = ST_ED;
                default:               nxt = st;
            endcase
        end else begin
            unique case (op)
                OP_RDMISS: begin
                    if (st == ST_ED)                       nxt = ST_RPO;
                    else if (st == ST_SC || st == ST_EC)   nxt = ST_SP;
                end
                OP_WRMISS:  nxt = (st == ST_ED) ? ST_WPO : ST_INV;
                OP_UPGRADE: if (st == ST_SC) nxt = ST_INV;
                default:    nxt = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_INV;
        else        st <= nxt;
    end

    // R4
    transient_resolves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st >= ST_RP) |=> (st < ST_RP));
    // R7
    wp_to_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WP) |=> (st == ST_ED));
endmodule

// File: rtl/coh_line_ctrl.sv
// Top: arbitrates requests, classifies the bus operation and drives all slots.
// Assumes requests are sampled each clock; those seen while busy are dropped.
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int N_CACHE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CACHE-1:0]     rd_req,
    input  logic [N_CACHE-1:0]     wr_req,
    output logic [STW*N_CACHE-1:0] line_state,
    output logic                   busy,
    output logic                   violation
);
    localparam int CW = $clog2(N_CACHE + 1);
    localparam int IW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1;

    line_st_t         st [N_CACHE];
    logic [CW-1:0]    cnt [NUM_ST];
    logic [N_CACHE-1:0] gnt;
    logic [IW-1:0]    gnt_idx;
    logic             gnt_vld;
    line_st_t         sel_st;
    logic             sel_wr;
    bus_op_t          op;

    coh_arbiter #(.N(N_CACHE), .IW(IW)) u_arb (
        .req(rd_req | wr_req), .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld)
    );

    coh_census #(.N(N_CACHE), .CW(CW)) u_census (
        .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt)
    );

    coh_guard #(.CW(CW)) u_guard (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .violation(violation)
    );

    // busy while any transient state exists
    always_comb begin
        busy = (cnt[int'(ST_RP)] != '0) || (cnt[int'(ST_WP)] != '0)
            || (cnt[int'(ST_RPO)] != '0) || (cnt[int'(ST_WPO)] != '0)
            || (cnt[int'(ST_SP)] != '0);
    end

    // classify the granted request into a bus operation
    always_comb begin
        sel_st = st[gnt_idx];
        sel_wr = wr_req[gnt_idx];
        op     = OP_NONE;
        if (!busy && gnt_vld) begin
            if (sel_wr) begin
                unique case (sel_st)
                    ST_INV:  op = OP_WRMISS;
                    ST_SC:   op = OP_UPGRADE;
                    ST_EC:   op = OP_SILENT;
                    default: op = OP_NONE;
                endcase
            end else if (sel_st == ST_INV) begin
                op = OP_RDMISS;
            end
        end
    end

    for (genvar i = 0; i < N_CACHE; i++) begin : g_slot
        coh_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .granted(gnt[i] && !busy),
            .op(op),
            .completing(busy),
            .any_rpo(cnt[int'(ST_RPO)] != '0),
            .any_sp(cnt[int'(ST_SP)] != '0),
            .multi_rp(cnt[int'(ST_RP)] >= CW'(2)),
            .st(st[i])
        );
        assign line_state[STW*i +: STW] = st[i];
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R7
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
endmodule

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   rd = '0;
    logic [N-1:0]   wr = '0;
    logic [4*N-1:0] ls;
    logic           busy, viol;
    int             exp_st [N];
    int             n_cmp = 0;
    int             n_bad = 0;
    bit             done = 1'b0;

    always #5 clk = ~clk;

    coh_line_ctrl #(.N_CACHE(N)) i_coh_line_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(rd), .wr_req(wr),
        .line_state(ls), .busy(busy), .violation(viol)
    );

    function automatic bit exp_busy();
        for (int i = 0; i < N; i++) if (exp_st[i] >= 4) return 1'b1;
        return 1'b0;
    endfunction

    // protocol model advanced once per clock edge
    function automatic void model_step(logic [N-1:0] r, logic [N-1:0] w);
        int n_rp = 0, n_resp = 0, g = -1;
        for (int i = 0; i < N; i++) begin
            if (exp_st[i] == 4) n_rp++;
            if (exp_st[i] == 6 || exp_st[i] == 8) n_resp++;
        end
        if (exp_busy()) begin
            for (int i = 0; i < N; i++) begin
                case (exp_st[i])
                    4:    exp_st[i] = (n_resp > 0 || n_rp > 1) ? 1 : 2;
                    5:    exp_st[i] = 3;
                    6, 8: exp_st[i] = 1;
                    7:    exp_st[i] = 0;
                    default: ;
                endcase
            end
            return;
        end
        for (int i = N - 1; i >= 0; i--) if (r[i] || w[i]) g = i;
        if (g < 0) return;
        if (w[g]) begin
            case (exp_st[g])
                0: begin
                    for (int j = 0; j < N; j++) exp_st[j] = (exp_st[j] == 3) ? 7 : 0;
                    exp_st[g] = 5;
                end
                1: begin
                    for (int j = 0; j < N; j++) if (exp_st[j] == 1) exp_st[j] = 0;
                    exp_st[g] = 3;
                end
                2: exp_st[g] = 3;
                default: ;
            endcase
        end else if (exp_st[g] == 0) begin
            for (int j = 0; j < N; j++) begin
                if (exp_st[j] == 3) exp_st[j] = 6;
                else if (exp_st[j] == 1 || exp_st[j] == 2) exp_st[j] = 8;
            end
            exp_st[g] = 4;
        end
    endfunction

    task automatic check_all(string tag);
        for (int i = 0; i < N; i++) begin
            n_cmp++;
            if (int'(ls[4*i +: 4]) != exp_st[i]) begin
                n_bad++;
                $display("FAIL %s cache%0d state actual=%0d expected=%0d", tag, i, ls[4*i +: 4], exp_st[i]);
            end
        end
        n_cmp++;
        if (busy !== exp_busy()) begin
            n_bad++;
            $display("FAIL %s busy actual=%0b expected=%0b", tag, busy, exp_busy());
        end
        n_cmp++;
        if (viol !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 violation actual=%0b expected=0", viol);
        end
    endtask

    task automatic cycle(logic [N-1:0] r, logic [N-1:0] w, string tag);
        @(negedge clk);
        rd = r;
        wr = w;
        @(posedge clk);
        model_step(r, w);
        #1;
        check_all(tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) exp_st[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        cycle(4'b0000, 4'b0000, "R1 idle");
        // R3 read miss, then R5 lone reader goes exclusive-clean
        cycle(4'b0001, 4'b0000, "R3 rd miss c0");
        cycle(4'b0000, 4'b0000, "R5 lone reader");
        // R8 silent write on exclusive-clean
        cycle(4'b0000, 4'b0001, "R8 silent write");
        cycle(4'b0000, 4'b0001, "R8 write hit dirty");
        // R3 read from dirty owner, R4 both shared
        cycle(4'b0010, 4'b0000, "R3 rd vs dirty owner");
        cycle(4'b0000, 4'b0000, "R4 owner completion");
        // R2 simultaneous: c2 read wins over c3 write; c3 write dropped during busy
        cycle(4'b0100, 4'b1000, "R2 priority");
        cycle(4'b0000, 4'b1000, "R4 sharer completion, R2 drop");
        cycle(4'b0000, 4'b0000, "R2 dropped not replayed");
        // R8 read hit
        cycle(4'b0010, 4'b0000, "R8 read hit");
        // R9 upgrade: c0 write beats c1 read
        cycle(4'b0010, 4'b0001, "R9 upgrade");
        // R6 write miss vs dirty owner, R7 completion
        cycle(4'b0000, 4'b0100, "R6 wr miss");
        cycle(4'b0000, 4'b0000, "R7 wr completion");
        // R6 write miss with only sharers
        cycle(4'b1000, 4'b0000, "R3 rd miss c3");
        cycle(4'b0000, 4'b0000, "R4 completion");
        cycle(4'b0000, 4'b0010, "R6 wr miss sharers");
        cycle(4'b0000, 4'b0000, "R7 completion");
        // random sweep over all rules
        for (int k = 0; k < 6000; k++) begin
            logic [N-1:0] r, w;
            r = N'($urandom & $urandom);
            w = N'($urandom & $urandom & $urandom);
            cycle(r, w, "R2-mix random R3/R4/R5/R6/R7/R8/R9");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule